// File: doc/BRIEF.md
# Trim DAC Mode and Latch Controller

This block is the command-execution core of a two-channel trim converter with a built-in non-volatile word store. A front end, which is not part of this block, turns serial traffic into a single-cycle command strobe carrying an opcode, a 7-bit word address and a 16-bit data word. The block carries out each command against a 128-word by 16-bit store model and two 8-bit converter setting latches. It keeps the write-enable flag and the power-down flag. It gates the converter output enable, returns read data, and models the self-timed programming period with a busy flag whose length is a parameter in clock cycles.

After power-up the block is write-protected and powered down. The first falling edge of the chip-select level fetches stored word 0 into the two latches and enables the outputs. This preload runs once per power-up. Commands are refused from reset until chip-select has returned high after that first low period. Word 0 is special: a write to it also loads the latches in normal mode, even when the store is protected. Power-down disables the outputs but keeps the latched codes, so they are restored unchanged when normal mode resumes.

Top module: `trim_dac_ctrl`

## Requirements
- R1: After reset the outputs are `dac_oe`=0, `busy`=0 and `rd_vld`=0. The block is write-disabled and in power-down mode. A WREN given before the preload has finished leaves the block write-disabled.
- R2: The first high-to-low change of `cs_i` after reset loads `ch0_code` with bits 15:8 of stored word 0 and `ch1_code` with bits 7:0 of it, and sets `dac_oe`=1. All of this is visible one cycle after the clock edge that sees the change.
- R3: Every strobe is refused from reset until `cs_i` returns high after the preload. A refused READ gives no `rd_vld`. Any later falling edge of `cs_i` leaves the latches unchanged.
- R4: WREN sets write-enable and WRDS clears it. A WRITE to addresses 1 to 127 changes the store only while write-enable is set. Otherwise it has no effect.
- R5: An accepted READ gives `rd_data` equal to the addressed word, with a one-cycle `rd_vld` pulse, in the cycle after the strobe. This holds whatever the write-enable state.
- R6: A WRITE to address 0 in normal mode always loads `ch0_code` from data bits 15:8 and `ch1_code` from data bits 7:0. It changes stored word 0 only while write-enable is set.
- R7: A WRITE to address 0 in power-down mode changes stored word 0 only while write-enable is set. It leaves both latches unchanged and keeps `dac_oe`=0.
- R8: CALL in normal mode loads `ch0_code` from bits 15:8 and `ch1_code` from bits 7:0 of the addressed word. In power-down mode CALL has no effect on the latches.
- R9: PDEN clears `dac_oe` in the next cycle and keeps both latch values. PDDS sets `dac_oe` again, and the outputs show the same codes as before power-down. No command changes the latches while in power-down mode.
- R10: A WRITE that changes the store raises `busy` from the next cycle for exactly PROG_CYCLES cycles. A strobe arriving while `busy` is 1 is refused. A WRITE that changes nothing does not raise `busy`.
- R11: The store is not cleared by reset. Its factory content for word i is {i XOR 8'hA5, NOT i}, with i taken as 8 bits, so word 0 is 16'hA5FF.
- R12: `cmd_op` encodes READ=0, WRITE=1, WREN=2, WRDS=3, PDEN=4, PDDS=5, CALL=6. Code 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| cs_i | input | 1 | Chip-select level, 1 = high |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode (see R12) |
| cmd_addr | input | 7 | Word address |
| cmd_wdata | input | 16 | Write data |
| ch0_code | output | 8 | Channel 0 latch value |
| ch1_code | output | 8 | Channel 1 latch value |
| dac_oe | output | 1 | Converter output enable |
| rd_data | output | 16 | Read data |
| rd_vld | output | 1 | Read data valid pulse |
| busy | output | 1 | Programming period in progress |

## Verification
Two functions can land in the same cycle: the end of a programming period and the arrival of the next command strobe. The bench holds a READ strobe steady across the last busy cycle. It expects no `rd_vld` from the edge that still sees `busy`, and a valid read of the freshly programmed word on the following edge. A write to word 0 likewise loads the latches and commits the store on one edge. The bench judges both halves: it reads the latches directly and the store through a later READ, with write-enable set and with it cleared.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_WREN  = 3'd2,
        OP_WRDS  = 3'd3,
        OP_PDEN  = 3'd4,
        OP_PDDS  = 3'd5,
        OP_CALL  = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PH_WAIT_FALL = 2'd0,
        PH_FIRST_LOW = 2'd1,
        PH_RUN       = 2'd2
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic wren;
        logic wrds;
        logic pden;
        logic pdds;
        logic call;
    } cmd_hit_t;

endpackage

// File: rtl/trim_cmd_decode.sv
module trim_cmd_decode
    import trim_pkg::*;
(
    input  logic           accept,
    input  logic [2:0]     op,
    output cmd_hit_t       hit
);

    always_comb begin
        hit = '0;
        if (accept) begin
            unique case (op_e'(op))
                OP_READ:  hit.rd   = 1'b1;
                OP_WRITE: hit.wr   = 1'b1;
                OP_WREN:  hit.wren = 1'b1;
                OP_WRDS:  hit.wrds = 1'b1;
                OP_PDEN:  hit.pden = 1'b1;
                OP_PDDS:  hit.pdds = 1'b1;
                OP_CALL:  hit.call = 1'b1;
                default:  hit      = '0;
            endcase
        end
    end

endmodule

// File: rtl/trim_store.sv
module trim_store #(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = WORD_W / 2;

    logic [WORD_W-1:0] cells [DEPTH];

    // factory content: upper half index xor A5, lower half inverted index
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i] = {HALF'(i) ^ HALF'(8'hA5), ~HALF'(i)};
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/trim_prog_timer.sv
module trim_prog_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/trim_dac_ctrl.sv
module trim_dac_ctrl
    import trim_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              cmd_vld,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W/2-1:0] ch0_code,
    output logic [WORD_W/2-1:0] ch1_code,
    output logic              dac_oe,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              busy
);

    localparam int CH_W = WORD_W / 2;

    typedef struct packed {
        phase_e            phase;
        logic              cs_last;
        logic              wen;
        logic              pdn;
        logic [CH_W-1:0]   ch0;
        logic [CH_W-1:0]   ch1;
        logic [WORD_W-1:0] rdat;
        logic              rvld;
    } st_t;

    st_t st_d, st_q;

    logic              accept;
    cmd_hit_t          hit;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] mem_rdata;
    logic              mem_we;
    logic              prog_start;
    logic              addr_is_zero;

    // views for the bound checker
    logic in_run, pd_mode, wr_en;

    assign accept       = cmd_vld && (st_q.phase == PH_RUN) && !busy;
    assign rd_addr      = (st_q.phase == PH_WAIT_FALL) ? '0 : cmd_addr;
    assign addr_is_zero = (cmd_addr == '0);

    trim_cmd_decode u_dec (
        .accept (accept),
        .op     (cmd_op),
        .hit    (hit)
    );

    trim_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (cmd_addr),
        .wr_data (cmd_wdata),
        .rd_addr (rd_addr),
        .rd_data (mem_rdata)
    );

    trim_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rvld    = 1'b0;
        st_d.cs_last = cs_i;
        mem_we       = 1'b0;
        prog_start   = 1'b0;

        unique case (st_q.phase)
            PH_WAIT_FALL: begin
                if (st_q.cs_last && !cs_i) begin
                    st_d.ch0   = mem_rdata[WORD_W-1:CH_W];
                    st_d.ch1   = mem_rdata[CH_W-1:0];
                    st_d.pdn   = 1'b0;
                    st_d.phase = PH_FIRST_LOW;
                end
            end
            PH_FIRST_LOW: begin
                if (cs_i) begin
                    st_d.phase = PH_RUN;
                end
            end
            default: begin
                if (hit.rd) begin
                    st_d.rdat = mem_rdata;
                    st_d.rvld = 1'b1;
                end
                if (hit.wr) begin
                    if (st_q.wen) begin
                        mem_we     = 1'b1;
                        prog_start = 1'b1;
                    end
                    if (addr_is_zero && !st_q.pdn) begin
                        st_d.ch0 = cmd_wdata[WORD_W-1:CH_W];
                        st_d.ch1 = cmd_wdata[CH_W-1:0];
                    end
                end
                if (hit.wren) st_d.wen = 1'b1;
                if (hit.wrds) st_d.wen = 1'b0;
                if (hit.pden) st_d.pdn = 1'b1;
                if (hit.pdds) st_d.pdn = 1'b0;
                if (hit.call && !st_q.pdn) begin
                    st_d.ch0 = mem_rdata[WORD_W-1:CH_W];
                    st_d.ch1 = mem_rdata[CH_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_WAIT_FALL;
            st_q.cs_last <= 1'b0;
            st_q.wen     <= 1'b0;
            st_q.pdn     <= 1'b1;
            st_q.ch0     <= '0;
            st_q.ch1     <= '0;
            st_q.rdat    <= '0;
            st_q.rvld    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch0_code = st_q.ch0;
    assign ch1_code = st_q.ch1;
    assign dac_oe   = (st_q.phase != PH_WAIT_FALL) && !st_q.pdn;
    assign rd_data  = st_q.rdat;
    assign rd_vld   = st_q.rvld;

    assign in_run  = (st_q.phase == PH_RUN);
    assign pd_mode = st_q.pdn;
    assign wr_en   = st_q.wen;

endmodule

// File: rtl/trim_dac_ctrl_chk.sv
module trim_dac_ctrl_chk #(
    parameter int CH_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_vld,
    input logic [2:0]      cmd_op,
    input logic [CH_W-1:0] ch0_code,
    input logic [CH_W-1:0] ch1_code,
    input logic            dac_oe,
    input logic            rd_vld,
    input logic            busy,
    input logic            in_run,
    input logic            pd_mode,
    input logic            wr_en
);

    // R1: nothing is produced before the preload period has ended
    p_quiet_before_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |-> (!busy && !rd_vld));

    // R5: an accepted read yields a valid pulse next cycle
    p_read_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && cmd_vld && !busy && cmd_op == 3'd0) |=> rd_vld);

    // R4: a protected write raises no busy period
    p_protected_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && cmd_vld && !busy && cmd_op == 3'd1 && !wr_en) |=> !busy);

    // R9: latches are frozen while powered down
    p_pd_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && pd_mode) |=> ($stable(ch0_code) && $stable(ch1_code)));

    // R9: power-down command drops the output enable
    p_pden_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && cmd_vld && !busy && cmd_op == 3'd4) |=> !dac_oe);

    // R10: a strobe during busy changes nothing
    p_busy_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_vld) |=> (!rd_vld && $stable(wr_en) && $stable(pd_mode)
                               && $stable(ch0_code) && $stable(ch1_code)));

endmodule

bind trim_dac_ctrl trim_dac_ctrl_chk #(
    .CH_W (WORD_W / 2)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .ch0_code (ch0_code),
    .ch1_code (ch1_code),
    .dac_oe   (dac_oe),
    .rd_vld   (rd_vld),
    .busy     (busy),
    .in_run   (in_run),
    .pd_mode  (pd_mode),
    .wr_en    (wr_en)
);

// File: tb/trim_dac_ctrl_bench.sv
module trim_dac_ctrl_bench;

    localparam int PROG = 16;
    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_WEN = 3'd2, C_WDS = 3'd3,
                           C_PDE = 3'd4, C_PDD = 3'd5, C_CALL = 3'd6, C_NOP = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_i = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [7:0]  ch0_code, ch1_code;
    logic        dac_oe, rd_vld, busy;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trim_dac_ctrl #(.PROG_CYCLES(PROG)) u_trim_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .cmd_vld(cmd_vld),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .ch0_code(ch0_code), .ch1_code(ch1_code), .dac_oe(dac_oe),
        .rd_data(rd_data), .rd_vld(rd_vld), .busy(busy)
    );

    function automatic logic [15:0] factory(input int i);
        return {8'(i) ^ 8'hA5, ~8'(i)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4 * PROG && busy; k++) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        issue(C_RD, a, 16'h0);
        chk(req, {15'h0, rd_vld, rd_data}, {15'h0, 1'b1, exp});
    endtask

    task automatic power_up();
        rst_n = 1'b0; cs_i = 1'b0; cmd_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        power_up();
        chk("R1 reset outputs", {29'h0, dac_oe, busy, rd_vld}, 32'h0);
        issue(C_WEN, 7'h0, 16'h0);
        issue(C_RD, 7'h3, 16'h0);
        chk("R3 read before preload refused", {31'h0, rd_vld}, 32'h0);
    endtask

    task automatic t_preload(input logic [15:0] w0);
        @(negedge clk) cs_i = 1'b1;
        @(negedge clk) cs_i = 1'b0;
        @(negedge clk);
        chk("R2 preload codes and enable", {15'h0, dac_oe, ch0_code, ch1_code}, {15'h0, 1'b1, w0});
        issue(C_RD, 7'h1, 16'h0);
        chk("R3 read in first low period refused", {31'h0, rd_vld}, 32'h0);
        @(negedge clk) cs_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_protect();
        read_chk("R11 factory word 3", 7'h3, factory(3));
        issue(C_WR, 7'h5, 16'hBEEF);
        chk("R10 protected write no busy", {31'h0, busy}, 32'h0);
        read_chk("R4 R1 protected write ignored", 7'h5, factory(5));
    endtask

    task automatic t_program();
        issue(C_WEN, 7'h0, 16'h0);
        issue(C_WR, 7'h5, 16'h1234);
        chk("R10 busy after commit", {31'h0, busy}, 32'h1);
        repeat (PROG - 1) @(negedge clk);
        chk("R10 busy in last cycle", {31'h0, busy}, 32'h1);
        cmd_vld = 1'b1; cmd_op = C_RD; cmd_addr = 7'h5;
        @(negedge clk);
        chk("R10 strobe in last busy cycle refused", {30'h0, rd_vld, busy}, 32'h0);
        @(negedge clk);
        cmd_vld = 1'b0;
        chk("R4 R5 read after programming", {15'h0, rd_vld, rd_data}, {15'h0, 1'b1, 16'h1234});
    endtask

    task automatic t_word0();
        issue(C_WDS, 7'h0, 16'h0);
        issue(C_WR, 7'h0, 16'h3C5A);
        chk("R6 protected word0 loads latches", {14'h0, busy, dac_oe, ch0_code, ch1_code}, {14'h0, 1'b0, 1'b1, 16'h3C5A});
        read_chk("R6 protected word0 store kept", 7'h0, 16'hA5FF);
        issue(C_WEN, 7'h0, 16'h0);
        issue(C_WR, 7'h0, 16'h7788);
        chk("R6 enabled word0 latches", {15'h0, busy, ch0_code, ch1_code}, {15'h0, 1'b1, 16'h7788});
        wait_idle();
        read_chk("R6 enabled word0 stored", 7'h0, 16'h7788);
    endtask

    task automatic t_call_pd();
        issue(C_CALL, 7'h5, 16'h0);
        chk("R8 call loads latches", {ch0_code, ch1_code}, 32'h1234);
        issue(C_PDE, 7'h0, 16'h0);
        chk("R9 pden disables keeps codes", {15'h0, dac_oe, ch0_code, ch1_code}, 32'h1234);
        issue(C_CALL, 7'h3, 16'h0);
        chk("R8 call ignored in power-down", {ch0_code, ch1_code}, 32'h1234);
        issue(C_WR, 7'h0, 16'h9911);
        chk("R7 pd word0 write latches kept", {15'h0, dac_oe, ch0_code, ch1_code}, 32'h1234);
        wait_idle();
        read_chk("R7 pd word0 stored", 7'h0, 16'h9911);
        issue(C_PDD, 7'h0, 16'h0);
        chk("R9 pdds restores", {15'h0, dac_oe, ch0_code, ch1_code}, {15'h0, 1'b1, 16'h1234});
        issue(C_NOP, 7'h0, 16'h5555);
        chk("R12 code 7 no effect", {14'h0, rd_vld, busy, ch0_code, ch1_code}, 32'h1234);
        @(negedge clk) cs_i = 1'b0;
        repeat (2) @(negedge clk);
        cs_i = 1'b1;
        @(negedge clk);
        chk("R3 second cs fall no reload", {ch0_code, ch1_code}, 32'h1234);
    endtask

    task automatic t_repower();
        power_up();
        chk("R1 repower outputs off", {31'h0, dac_oe}, 32'h0);
        t_preload(16'h9911);
        issue(C_WR, 7'h6, 16'hAAAA);
        chk("R1 write disabled after repower", {31'h0, busy}, 32'h0);
        read_chk("R11 store kept over reset", 7'h5, 16'h1234);
    endtask

    initial begin
        t_reset();
        t_preload(16'hA5FF);
        t_protect();
        t_program();
        t_word0();
        t_call_pd();
        t_repower();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule